// File: doc/BRIEF.md
# Bus and Local Wake-Up Filter

This block watches for wake-up requests while the transceiver sits in one of its low-power modes. It has two sources. The first is the digitized output of the low-power differential bus receiver: a remote wake-up is accepted only after a two-pulse pattern. The pattern is a dominant period of at least a minimum length, then a recessive period of at least a minimum length, repeated once. The second source is a local wake pin: a level change in either direction that holds for a debounce time counts as a local wake-up. The debounced pin level also sets the direction of the pin's bias current source.

Both inputs pass through a synchronizer. All three times are parameters given in clock cycles. Detection is live only when the mode input selects standby, go-to-sleep or sleep, and when the external undervoltage block input is low. After detection becomes live, only the first wake-up produces an output pulse. Disabling detection clears any partial pattern and arms the block again for the next enable.

Top module: `wake_filter`

## Requirements
- R1: Detection is live only when `mode` is 3'd2 (standby), 3'd3 (go-to-sleep) or 3'd4 (sleep). For codes 3'd0 (normal), 3'd1 (receive-only) and 3'd5 to 3'd7, no wake pulse is produced.
- R2: A remote pulse follows a bus sequence of dominant for at least T_DOM_CYC cycles, recessive for at least T_REC_CYC, dominant for at least T_DOM_CYC and recessive for at least T_REC_CYC. It is visible after the (SYNC_STAGES+T_REC_CYC)-th rising edge that sees the final recessive level at the input.
- R3: A dominant period shorter than T_DOM_CYC discards the pattern in progress, and no remote pulse results from it.
- R4: A recessive period shorter than T_REC_CYC discards the pattern in progress. The dominant period that ends it is taken as the first period of a fresh pattern.
- R5: A level change on `wake_pin`, rising or falling, that holds for T_WAKE_CYC cycles gives a local pulse. The pulse is visible after the (SYNC_STAGES+T_WAKE_CYC)-th rising edge that sees the new level.
- R6: A `wake_pin` excursion shorter than T_WAKE_CYC cycles gives no local pulse and leaves `wake_pull_up` unchanged.
- R7: `wake_pull_up` equals the debounced pin level in every mode (1 = pull-up, 0 = pull-down). It updates in the same cycle in which a local pulse would appear, and it is 0 after reset.
- R8: While `uv_block` is 1, no wake pulse of either kind is produced.
- R9: Once detection is live, only the first wake-up event produces a pulse. Later events give none until detection has been disabled and enabled again.
- R10: Disabling detection for a single cycle clears a partly received remote pattern.
- R11: If a remote pattern and a local change complete in the same cycle, both pulses appear in that cycle.
- R12: Each pulse lasts exactly one cycle. Both pulse outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Operating mode code of the transceiver |
| uv_block | input | 1 | Undervoltage waiting period; blocks detection when 1 |
| bus_dominant | input | 1 | Low-power receiver output, 1 = dominant |
| wake_pin | input | 1 | Raw level of the local wake pin |
| remote_wake | output | 1 | One-cycle pulse on a valid bus wake-up |
| local_wake | output | 1 | One-cycle pulse on a valid pin wake-up |
| wake_pull_up | output | 1 | Bias direction: 1 = pull-up, 0 = pull-down |

## Verification
The remote pattern recognizer and the pin debouncer can both finish in the same cycle, and they share a single arm flag. The bench provokes this by placing the pin change exactly T_WAKE_CYC cycles before the cycle in which the last recessive period reaches its minimum. It then expects one remote pulse and one local pulse in the same sampled cycle, with no further pulse afterwards. Random bus patterns with lengths close to the thresholds, in random modes, check the remote timing and the mode gating against cycle numbers that the bench computes.

// File: rtl/wkf_pkg.sv
package wkf_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'd0,
        MODE_RXONLY  = 3'd1,
        MODE_STANDBY = 3'd2,
        MODE_GTSLEEP = 3'd3,
        MODE_SLEEP   = 3'd4
    } wkf_mode_e;

    typedef enum logic [2:0] {
        PAT_IDLE,
        PAT_DOM1,
        PAT_REC1,
        PAT_DOM2,
        PAT_REC2
    } wkf_pat_e;

    function automatic logic is_low_power(input logic [2:0] m);
        return (m == MODE_STANDBY) || (m == MODE_GTSLEEP) || (m == MODE_SLEEP);
    endfunction

endpackage

// File: rtl/wkf_sync.sv
module wkf_sync #(
    parameter int          STAGES     = 2,
    parameter int          W          = 2,
    parameter logic [W-1:0] RESET_WORD = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] chain_d, chain_q;

            always_comb begin
                chain_d[0] = din;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RESET_WORD}};
                end else begin
                    chain_q <= chain_d;
                end
            end

            assign dout = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/wkf_bus_pattern.sv
module wkf_bus_pattern
    import wkf_pkg::*;
#(
    parameter int T_DOM = 20,
    parameter int T_REC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dom,
    output logic done
);

    localparam int T_MAX = (T_DOM > T_REC) ? T_DOM : T_REC;
    localparam int CW    = $clog2(T_MAX + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(T_MAX);
    localparam logic [CW-1:0] DOM_MIN  = CW'(T_DOM);
    localparam logic [CW-1:0] REC_MIN  = CW'(T_REC);
    localparam logic [CW-1:0] REC_LAST = CW'(T_REC - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        wkf_pat_e        st;
        logic [CW-1:0]   cnt;
    } pat_reg_t;

    pat_reg_t r_d, r_q;
    logic [CW-1:0] cnt_inc;
    logic          dom_ok, rec_ok;

    always_comb begin
        r_d     = r_q;
        done    = 1'b0;
        cnt_inc = (r_q.cnt == CNT_MAX) ? r_q.cnt : r_q.cnt + ONE;
        dom_ok  = (r_q.cnt >= DOM_MIN);
        rec_ok  = (r_q.cnt >= REC_MIN);

        if (!en) begin
            r_d.st  = PAT_IDLE;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                PAT_IDLE: begin
                    if (dom) begin
                        r_d.st  = PAT_DOM1;
                        r_d.cnt = ONE;
                    end
                end
                PAT_DOM1: begin
                    if (dom) begin
                        r_d.cnt = cnt_inc;
                    end else if (dom_ok) begin
                        r_d.st  = PAT_REC1;
                        r_d.cnt = ONE;
                    end else begin
                        r_d.st  = PAT_IDLE;
                        r_d.cnt = '0;
                    end
                end
                PAT_REC1: begin
                    if (!dom) begin
                        r_d.cnt = cnt_inc;
                    end else if (rec_ok) begin
                        r_d.st  = PAT_DOM2;
                        r_d.cnt = ONE;
                    end else begin
                        r_d.st  = PAT_DOM1;
                        r_d.cnt = ONE;
                    end
                end
                PAT_DOM2: begin
                    if (dom) begin
                        r_d.cnt = cnt_inc;
                    end else if (dom_ok) begin
                        if (T_REC <= 1) begin
                            done    = 1'b1;
                            r_d.st  = PAT_IDLE;
                            r_d.cnt = '0;
                        end else begin
                            r_d.st  = PAT_REC2;
                            r_d.cnt = ONE;
                        end
                    end else begin
                        r_d.st  = PAT_IDLE;
                        r_d.cnt = '0;
                    end
                end
                PAT_REC2: begin
                    if (dom) begin
                        r_d.st  = PAT_DOM1;
                        r_d.cnt = ONE;
                    end else if (r_q.cnt == REC_LAST) begin
                        done    = 1'b1;
                        r_d.st  = PAT_IDLE;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = cnt_inc;
                    end
                end
                default: begin
                    r_d.st  = PAT_IDLE;
                    r_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= PAT_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/wkf_pin_debounce.sv
module wkf_pin_debounce #(
    parameter int   T_WAKE      = 200,
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic flip
);

    localparam int CW = $clog2(T_WAKE + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(T_WAKE - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } deb_reg_t;

    deb_reg_t d_d, d_q;
    logic     differ;

    always_comb begin
        d_d    = d_q;
        differ = (pin != d_q.lvl);
        flip   = differ && (d_q.cnt == CNT_LAST);
        if (!differ) begin
            d_d.cnt = '0;
        end else if (flip) begin
            d_d.lvl = pin;
            d_d.cnt = '0;
        end else begin
            d_d.cnt = d_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q.lvl <= RESET_LEVEL;
            d_q.cnt <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign level = d_q.lvl;

endmodule

// File: rtl/wake_filter.sv
module wake_filter
    import wkf_pkg::*;
#(
    parameter int   T_DOM_CYC        = 20,
    parameter int   T_REC_CYC        = 20,
    parameter int   T_WAKE_CYC       = 200,
    parameter int   SYNC_STAGES      = 2,
    parameter logic WAKE_RESET_LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       uv_block,
    input  logic       bus_dominant,
    input  logic       wake_pin,
    output logic       remote_wake,
    output logic       local_wake,
    output logic       wake_pull_up
);

    typedef struct packed {
        logic armed;
        logic remote_pulse;
        logic local_pulse;
    } top_reg_t;

    logic [1:0] raw_in, synced;
    logic       det_en;
    logic       pat_done;
    logic       pin_flip;
    logic       pin_level;
    top_reg_t   st_d, st_q;

    assign raw_in = {bus_dominant, wake_pin};

    wkf_sync #(
        .STAGES     (SYNC_STAGES),
        .W          (2),
        .RESET_WORD ({1'b0, WAKE_RESET_LEVEL})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (synced)
    );

    assign det_en = is_low_power(mode) && !uv_block;

    wkf_bus_pattern #(
        .T_DOM (T_DOM_CYC),
        .T_REC (T_REC_CYC)
    ) u_pattern (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (det_en),
        .dom   (synced[1]),
        .done  (pat_done)
    );

    wkf_pin_debounce #(
        .T_WAKE      (T_WAKE_CYC),
        .RESET_LEVEL (WAKE_RESET_LEVEL)
    ) u_debounce (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (synced[0]),
        .level (pin_level),
        .flip  (pin_flip)
    );

    always_comb begin
        st_d              = st_q;
        st_d.remote_pulse = det_en && st_q.armed && pat_done;
        st_d.local_pulse  = det_en && st_q.armed && pin_flip;
        st_d.armed        = det_en ? (st_q.armed && !(pat_done || pin_flip)) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed        <= 1'b1;
            st_q.remote_pulse <= 1'b0;
            st_q.local_pulse  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign remote_wake  = st_q.remote_pulse;
    assign local_wake   = st_q.local_pulse;
    assign wake_pull_up = pin_level;

endmodule

// File: rtl/wake_filter_chk.sv
module wake_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       uv_block,
    input logic       remote_wake,
    input logic       local_wake,
    input logic       wake_pull_up
);

    logic live;
    logic seen_d, seen_q;

    assign live = ((mode == 3'd2) || (mode == 3'd3) || (mode == 3'd4)) && !uv_block;

    always_comb begin
        if (!live) begin
            seen_d = 1'b0;
        end else begin
            seen_d = seen_q || remote_wake || local_wake;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= seen_d;
        end
    end

    AST_REMOTE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        remote_wake |-> $past((mode == 3'd2) || (mode == 3'd3) || (mode == 3'd4))); // R1
    AST_LOCAL_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake |-> $past((mode == 3'd2) || (mode == 3'd3) || (mode == 3'd4))); // R1
    AST_UV_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_wake || local_wake) |-> !$past(uv_block)); // R8
    AST_REMOTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        remote_wake |=> !remote_wake); // R12
    AST_LOCAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake |=> !local_wake); // R12
    AST_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_wake || local_wake) |-> !seen_q); // R9
    AST_LOCAL_MOVES_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake |-> !$stable(wake_pull_up)); // R7

endmodule

bind wake_filter wake_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .uv_block     (uv_block),
    .remote_wake  (remote_wake),
    .local_wake   (local_wake),
    .wake_pull_up (wake_pull_up)
);

// File: tb/wake_filter_bench.sv
module wake_filter_bench;

    localparam int TD = 6;
    localparam int TR = 5;
    localparam int TW = 10;
    localparam int SY = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd2;
    logic       uv_block = 1'b0;
    logic       bus_dominant = 1'b0;
    logic       wake_pin = 1'b0;
    logic       remote_wake, local_wake, wake_pull_up;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    int r_cnt = 0, l_cnt = 0, both_cnt = 0;
    int r_cyc = -1, l_cyc = -1;
    int seg[8];
    bit finished = 1'b0;

    wake_filter #(
        .T_DOM_CYC   (TD),
        .T_REC_CYC   (TR),
        .T_WAKE_CYC  (TW),
        .SYNC_STAGES (SY)
    ) u_wake_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .uv_block     (uv_block),
        .bus_dominant (bus_dominant),
        .wake_pin     (wake_pin),
        .remote_wake  (remote_wake),
        .local_wake   (local_wake),
        .wake_pull_up (wake_pull_up)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (remote_wake) begin r_cnt++; r_cyc = cyc; end
            if (local_wake)  begin l_cnt++; l_cyc = cyc; end
            if (remote_wake && local_wake) both_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        r_cnt = 0; l_cnt = 0; both_cnt = 0; r_cyc = -1; l_cyc = -1;
    endtask

    task automatic rearm();
        mode = 3'd0; uv_block = 1'b0; bus_dominant = 1'b0;
        tick(3);
        mode = 3'd2;
        tick(SY + TR + 3);
        clear_counts();
    endtask

    function automatic bit lp_mode(input int m);
        return (m >= 2) && (m <= 4);
    endfunction

    // seg[] alternates dominant/recessive lengths starting dominant
    task automatic drive_list(input int n, input int pin_at, input bit pin_val, output int start);
        int total = 0;
        for (int k = 0; k < n; k++) total += seg[k];
        start = cyc;
        for (int i = 0; i < total + TR + SY + 6; i++) begin
            int acc = 0;
            bit lvl = 1'b0;
            for (int k = 0; k < n; k++) begin
                if (i >= acc && i < acc + seg[k]) lvl = (k % 2 == 0);
                acc += seg[k];
            end
            bus_dominant = lvl;
            if (i == pin_at) wake_pin = pin_val;
            @(negedge clk);
        end
        bus_dominant = 1'b0;
    endtask

    function automatic int remote_due(input int start, input int d1, input int r1, input int d2);
        return start + d1 + r1 + d2 + TR + SY;
    endfunction

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R0 actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int st, m, d1, r1, d2, exp_hit;
        void'($urandom(32'd20240611));
        tick(3);
        // R12 R7: reset state
        chk(remote_wake == 1'b0 && local_wake == 1'b0, "R12 reset pulses", remote_wake + local_wake, 0);
        chk(wake_pull_up == 1'b0, "R7 reset pull", wake_pull_up, 0);
        rst_n = 1'b1;
        tick(2);
        rearm();

        // R2 exact boundary pattern, R12 single pulse
        seg = '{TD, TR, TD, 0, 0, 0, 0, 0};
        drive_list(3, -1, 1'b0, st);
        chk(r_cnt == 1, "R2 boundary pattern count", r_cnt, 1);
        chk(r_cyc == remote_due(st, TD, TR, TD), "R2 pulse cycle", r_cyc, remote_due(st, TD, TR, TD));
        chk(l_cnt == 0, "R12 no stray local", l_cnt, 0);

        // R3 short first / second dominant
        rearm();
        seg = '{TD - 1, TR, TD, 0, 0, 0, 0, 0};
        drive_list(3, -1, 1'b0, st);
        chk(r_cnt == 0, "R3 short first dominant", r_cnt, 0);
        rearm();
        seg = '{TD, TR, TD - 1, 0, 0, 0, 0, 0};
        drive_list(3, -1, 1'b0, st);
        chk(r_cnt == 0, "R3 short second dominant", r_cnt, 0);

        // R4 short recessive
        rearm();
        seg = '{TD, TR - 1, TD, 0, 0, 0, 0, 0};
        drive_list(3, -1, 1'b0, st);
        chk(r_cnt == 0, "R4 short first recessive", r_cnt, 0);
        rearm();
        seg = '{TD, TR, TD, TR - 1, TD, TR, TD, 0};
        drive_list(7, -1, 1'b0, st);
        chk(r_cnt == 1, "R4 restart count", r_cnt, 1);
        chk(r_cyc == remote_due(st + TD + TR + TD + TR - 1, TD, TR, TD), "R4 restart cycle",
            r_cyc, remote_due(st + TD + TR + TD + TR - 1, TD, TR, TD));

        // R1 go-to-sleep and sleep codes
        rearm(); mode = 3'd3;
        seg = '{TD + 2, TR + 1, TD, 0, 0, 0, 0, 0};
        drive_list(3, -1, 1'b0, st);
        chk(r_cnt == 1 && r_cyc == remote_due(st, TD + 2, TR + 1, TD), "R1 go-to-sleep", r_cyc,
            remote_due(st, TD + 2, TR + 1, TD));
        rearm(); mode = 3'd4;
        seg = '{TD, TR, TD, 0, 0, 0, 0, 0};
        drive_list(3, -1, 1'b0, st);
        chk(r_cnt == 1, "R1 sleep", r_cnt, 1);
        // R1 disabled codes
        for (int c = 0; c < 8; c++) begin
            if (!lp_mode(c)) begin
                rearm(); mode = 3'(c);
                seg = '{TD, TR, TD, 0, 0, 0, 0, 0};
                drive_list(3, -1, 1'b0, st);
                chk(r_cnt == 0, $sformatf("R1 disabled mode %0d", c), r_cnt, 0);
            end
        end

        // R8 undervoltage block, R7 pull follows anyway
        rearm(); uv_block = 1'b1;
        seg = '{TD, TR, TD, 0, 0, 0, 0, 0};
        drive_list(3, 2, 1'b1, st);
        chk(r_cnt == 0 && l_cnt == 0, "R8 blocked", r_cnt + l_cnt, 0);
        chk(wake_pull_up == 1'b1, "R7 pull follows while blocked", wake_pull_up, 1);
        uv_block = 1'b0;

        // R5 falling and rising local wake
        rearm();
        st = cyc; wake_pin = 1'b0; tick(TW + SY + 3);
        chk(l_cnt == 1 && l_cyc == st + TW + SY, "R5 falling edge", l_cyc, st + TW + SY);
        chk(wake_pull_up == 1'b0, "R7 pull-down after fall", wake_pull_up, 0);
        rearm();
        st = cyc; wake_pin = 1'b1; tick(TW + SY + 3);
        chk(l_cnt == 1 && l_cyc == st + TW + SY, "R5 rising edge", l_cyc, st + TW + SY);
        chk(wake_pull_up == 1'b1, "R7 pull-up after rise", wake_pull_up, 1);

        // R6 short glitch ignored
        rearm();
        wake_pin = 1'b0; tick(TW - 1); wake_pin = 1'b1; tick(TW + SY + 3);
        chk(l_cnt == 0, "R6 glitch pulse", l_cnt, 0);
        chk(wake_pull_up == 1'b1, "R6 pull unchanged", wake_pull_up, 1);

        // R9 only the first wake-up
        rearm();
        seg = '{TD, TR, TD, 0, 0, 0, 0, 0};
        drive_list(3, -1, 1'b0, st);
        drive_list(3, -1, 1'b0, st);
        chk(r_cnt == 1, "R9 second pattern ignored", r_cnt, 1);
        wake_pin = 1'b0; tick(TW + SY + 3);
        chk(l_cnt == 0, "R9 later local ignored", l_cnt, 0);
        chk(wake_pull_up == 1'b0, "R7 pull follows after wake", wake_pull_up, 0);

        // R7 pull follows in normal mode
        mode = 3'd0; wake_pin = 1'b1; tick(TW + SY + 3);
        chk(wake_pull_up == 1'b1 && l_cnt == 0, "R7 normal mode pull", wake_pull_up, 1);

        // R10 disable clears partial pattern
        rearm();
        bus_dominant = 1'b1; tick(TD);
        bus_dominant = 1'b0; tick(TR);
        mode = 3'd0; tick(1); mode = 3'd2;
        bus_dominant = 1'b1; tick(TD);
        bus_dominant = 1'b0; tick(TR + SY + 6);
        chk(r_cnt == 0, "R10 cleared by disable", r_cnt, 0);

        // R11 simultaneous completion
        rearm();
        seg = '{TD, TR, TD, 0, 0, 0, 0, 0};
        drive_list(3, TD + TR + TD + TR - TW, 1'b0, st);
        chk(both_cnt == 1 && r_cnt == 1 && l_cnt == 1, "R11 both in one cycle", both_cnt, 1);
        chk(r_cyc == l_cyc, "R11 same cycle", l_cyc, r_cyc);

        // random patterns near thresholds across modes (R1 R2 R3 R4)
        for (int t = 0; t < 40; t++) begin
            rearm();
            m  = $urandom_range(4, 0);
            d1 = TD - 2 + $urandom_range(5, 0);
            r1 = TR - 2 + $urandom_range(5, 0);
            d2 = TD - 2 + $urandom_range(5, 0);
            mode = 3'(m);
            seg = '{d1, r1, d2, 0, 0, 0, 0, 0};
            drive_list(3, -1, 1'b0, st);
            exp_hit = (lp_mode(m) && d1 >= TD && r1 >= TR && d2 >= TD) ? 1 : 0;
            chk(r_cnt == exp_hit, "R2 random count", r_cnt, exp_hit);
            if (exp_hit == 1)
                chk(r_cyc == remote_due(st, d1, r1, d2), "R2 random cycle", r_cyc,
                    remote_due(st, d1, r1, d2));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule